// File: doc/BRIEF.md
# Glitchless Output-Enable Gating Controller

This block gates a set of clock outputs under the control of a few active-low enable pins. A mapping bus ties each enable pin to any subset of the outputs. An output runs only while none of the pins tied to it asks for a disable. Each output has its own source clock. The enable request is resynchronised into that clock's domain, and the gate then opens or closes only at a clock edge that cannot cut a pulse short.

Each output also has its own idle behaviour while gated. It can be held low, held high, or released to high impedance, which is shown on a separate per-output drive-enable line. It can also be marked unused, in which case it stays quiet whatever the enable pins do. A global power-down input sends every output to its idle behaviour through the same glitch-free path.

Top module: `oe_gate_ctrl`

## Requirements
- R1: Enable pins are active low. An output tied to exactly one pin runs while that pin is low and is gated while it is high.
- R2: When several pins are tied to one output, any one of them being high gates the output, whatever the levels of the others.
- R3: An output with no pin tied to it runs continuously, unless it is unused or power-down is active.
- R4: A change in an output's run request reaches that output's gate only after SYNC_STAGES rising edges of the output's own source clock.
- R5: In the held-low and high-impedance idle modes, the gate opens only at a falling source edge. The first pulse therefore starts on a rising edge, and every high pulse lasts a full source high phase.
- R6: In the held-low and high-impedance idle modes, the gate closes only at a falling source edge. A high phase already in progress is completed, and no short pulse appears.
- R7: In the held-high idle mode, the gate changes only at rising source edges. Every low pulse lasts a full source low phase.
- R8: The idle mode field is idle_cfg[2i+1:2i]. Code 00 drives 0 with drive-enable 1. Code 01 drives 1 with drive-enable 1. Code 10 drives 0 with drive-enable 0 while the gate is closed, and drive-enable 1 while the gate is open.
- R9: Code 11 marks the output as unused: clk_out and clk_oe are both 0 whatever the pins do.
- R10: While pwr_dn is 1, every output's run request is 0, and the output reaches its idle state through the same synchronised gate.
- R11: While rst_n is 0, all gates are closed and each output shows its idle state.
- R12: Bit link_map[j*N_OUT+i] set to 1 ties enable pin j to output i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | N_OUT | Source clock of each output |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Global power-down, active high |
| oe_n | input | N_EN | Active-low enable pins |
| link_map | input | N_EN*N_OUT | Pin-to-output ties, bit j*N_OUT+i |
| idle_cfg | input | 2*N_OUT | Two-bit idle mode per output |
| clk_out | output | N_OUT | Gated clock outputs |
| clk_oe | output | N_OUT | Per-output drive enable (0 = high impedance) |

## Verification
The bench builds the block with eight outputs, three enable pins and a three-stage synchroniser. The deeper chain makes the R4 latency distinguishable from an off-by-one. Even and odd outputs run on two unrelated clock periods, so gate timing is exercised in two domains at once. The eight outputs cover every idle code, one output with no tie, and outputs tied to two pins, so the dominance, unlinked and unused cases are all reachable under random pin toggling. Every emitted pulse is timed against the nominal phase width.

// File: rtl/oe_gate_pkg.sv
`timescale 1ns/100ps
package oe_gate_pkg;

  typedef enum logic [1:0] {
    IDLE_LOW  = 2'b00,
    IDLE_HIGH = 2'b01,
    IDLE_HIZ  = 2'b10,
    IDLE_OFF  = 2'b11
  } idle_mode_e;

  // a tied pin that sits high asks for a disable
  function automatic logic pin_blocks(input logic tied, input logic pin_n);
    return tied & pin_n;
  endfunction

  function automatic logic mode_usable(input idle_mode_e m);
    return m != IDLE_OFF;
  endfunction

  // gate closes on falling edges in these modes, on rising edges otherwise
  function automatic logic low_phase_gate(input idle_mode_e m);
    return (m == IDLE_LOW) || (m == IDLE_HIZ);
  endfunction

endpackage

// File: rtl/oe_req_decode.sv
`timescale 1ns/100ps
module oe_req_decode
  import oe_gate_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int N_EN  = 3
) (
  input  logic [N_EN-1:0]       oe_n,
  input  logic [N_EN*N_OUT-1:0] link_map,
  input  logic [2*N_OUT-1:0]    idle_cfg,
  input  logic                  pwr_dn,
  output logic [N_OUT-1:0]      run_req
);

  always_comb begin
    for (int i = 0; i < N_OUT; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N_EN; j++) begin
        blocked = blocked | pin_blocks(link_map[j*N_OUT+i], oe_n[j]);
      end
      run_req[i] = !blocked && !pwr_dn && mode_usable(idle_mode_e'(idle_cfg[2*i +: 2]));
    end
  end

endmodule

// File: rtl/oe_sync.sv
`timescale 1ns/100ps
module oe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/oe_out_gate.sv
`timescale 1ns/100ps
module oe_out_gate
  import oe_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open_sync,
  input  idle_mode_e mode,
  output logic       pad_out,
  output logic       pad_oe
);

  logic gate_lo;   // updated on falling edges
  logic gate_hi;   // updated on rising edges

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_lo <= 1'b0;
    else        gate_lo <= open_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_hi <= 1'b0;
    else        gate_hi <= open_sync;
  end

  always_comb begin
    unique case (mode)
      IDLE_LOW:  begin pad_out = clk & gate_lo;  pad_oe = 1'b1;    end
      IDLE_HIZ:  begin pad_out = clk & gate_lo;  pad_oe = gate_lo; end
      IDLE_HIGH: begin pad_out = clk | ~gate_hi; pad_oe = 1'b1;    end
      default:   begin pad_out = 1'b0;           pad_oe = 1'b0;    end
    endcase
  end

  // sampled just before a falling edge the source is high: a closed gate shows no pulse
  assert_closed_no_pulse_R6: assert property (@(negedge clk) disable iff (!rst_n)
    (low_phase_gate(mode) && !gate_lo) |-> !pad_out);

  assert_open_full_high_R5: assert property (@(negedge clk) disable iff (!rst_n)
    (low_phase_gate(mode) && gate_lo) |-> pad_out);

  // sampled just before a rising edge the source is low
  assert_closed_held_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDLE_HIGH && !gate_hi) |-> pad_out);

  assert_hiz_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDLE_HIZ && !gate_lo) |-> !pad_oe);

  assert_unused_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDLE_OFF) |-> (!pad_oe && !pad_out));

endmodule

// File: rtl/oe_gate_ctrl.sv
`timescale 1ns/100ps
module oe_gate_ctrl
  import oe_gate_pkg::*;
#(
  parameter int N_OUT       = 8,
  parameter int N_EN        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic [N_OUT-1:0]      src_clk,
  input  logic                  rst_n,
  input  logic                  pwr_dn,
  input  logic [N_EN-1:0]       oe_n,
  input  logic [N_EN*N_OUT-1:0] link_map,
  input  logic [2*N_OUT-1:0]    idle_cfg,
  output logic [N_OUT-1:0]      clk_out,
  output logic [N_OUT-1:0]      clk_oe
);

  logic [N_OUT-1:0] run_req;
  logic [N_OUT-1:0] run_sync;

  oe_req_decode #(.N_OUT(N_OUT), .N_EN(N_EN)) u_decode (
    .oe_n     (oe_n),
    .link_map (link_map),
    .idle_cfg (idle_cfg),
    .pwr_dn   (pwr_dn),
    .run_req  (run_req)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic [N_EN-1:0] tied_pins;
    idle_mode_e      mode;

    for (genvar j = 0; j < N_EN; j++) begin : g_col
      assign tied_pins[j] = link_map[j*N_OUT+i];
    end
    assign mode = idle_mode_e'(idle_cfg[2*i +: 2]);

    oe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (src_clk[i]),
      .rst_n (rst_n),
      .d     (run_req[i]),
      .q     (run_sync[i])
    );

    oe_out_gate u_gate (
      .clk       (src_clk[i]),
      .rst_n     (rst_n),
      .open_sync (run_sync[i]),
      .mode      (mode),
      .pad_out   (clk_out[i]),
      .pad_oe    (clk_oe[i])
    );

    assert_disable_wins_R2: assert property (@(posedge src_clk[i]) disable iff (!rst_n)
      (|(tied_pins & oe_n)) |-> !run_req[i]);

    assert_untied_runs_R3: assert property (@(posedge src_clk[i]) disable iff (!rst_n)
      (tied_pins == '0 && !pwr_dn && mode != IDLE_OFF) |-> run_req[i]);

    assert_power_down_R10: assert property (@(posedge src_clk[i]) disable iff (!rst_n)
      pwr_dn |-> !run_req[i]);
  end

endmodule

// File: tb/test_oe_gate_ctrl.sv
`timescale 1ns/100ps
module test_oe_gate_ctrl;

  localparam real CLK_PERIOD   = 10.0;
  localparam real CLK_B_PERIOD = 14.0;
  localparam int  N_OUT = 8;
  localparam int  N_EN  = 3;
  localparam int  SYNC  = 3;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  always #(CLK_PERIOD/2)   clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  logic [N_OUT-1:0]      src;
  logic                  rst_n;
  logic                  pwr_dn;
  logic [N_EN-1:0]       oe_n;
  logic [N_EN*N_OUT-1:0] link_map;
  logic [2*N_OUT-1:0]    idle_cfg;
  logic [N_OUT-1:0]      clk_out;
  logic [N_OUT-1:0]      clk_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  oe_gate_ctrl #(.N_OUT(N_OUT), .N_EN(N_EN), .SYNC_STAGES(SYNC)) i_oe_gate_ctrl (
    .src_clk(src), .rst_n(rst_n), .pwr_dn(pwr_dn), .oe_n(oe_n),
    .link_map(link_map), .idle_cfg(idle_cfg), .clk_out(clk_out), .clk_oe(clk_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_of(int i);
    return idle_cfg[2*i +: 2];
  endfunction

  // R12: pin j reaches output i through bit j*N_OUT+i
  function automatic int tie_count(int i);
    int c = 0;
    for (int j = 0; j < N_EN; j++) if (link_map[j*N_OUT+i]) c++;
    return c;
  endfunction

  function automatic bit any_tied_high(int i);
    for (int j = 0; j < N_EN; j++) if (link_map[j*N_OUT+i] && oe_n[j]) return 1;
    return 0;
  endfunction

  function automatic bit want_run(int i);
    return !any_tied_high(i) && !pwr_dn && mode_of(i) != 2'b11;
  endfunction

  function automatic string reason(int i);
    if (pwr_dn)              return "R10";
    if (mode_of(i) == 2'b11) return "R9";
    if (tie_count(i) == 0)   return "R3";
    if (tie_count(i) > 1)    return "R2";
    return "R1";
  endfunction

  for (genvar i = 0; i < N_OUT; i++) begin : g_ref
    if (i % 2 == 0) begin : g_a
      assign src[i] = clk_a;
    end else begin : g_b
      assign src[i] = clk_b;
    end

    bit  hist[$];
    bit  g_fall;
    bit  g_rise;
    real half;
    real t_edge;
    bit  t_valid;

    initial half = (i % 2 == 0) ? CLK_PERIOD/2 : CLK_B_PERIOD/2;

    // behavioural synchroniser: oldest sample at the front
    always @(posedge src[i] or negedge rst_n) begin
      if (!rst_n) begin
        hist = {};
        for (int k = 0; k < SYNC; k++) hist.push_back(1'b0);
        g_rise = 0;
      end else begin
        g_rise = hist[0];
        hist.push_back(want_run(i));
        void'(hist.pop_front());
      end
    end

    always @(negedge src[i] or negedge rst_n) begin
      if (!rst_n) g_fall = 0;
      else        g_fall = hist[0];
    end

    task automatic compare_now();
      bit s;
      bit eo, ee;
      bit gate;
      string tag;
      s = src[i];
      gate = (mode_of(i) == 2'b01) ? g_rise : g_fall;
      case (mode_of(i))
        2'b00:   begin eo = g_fall & s;   ee = 1;      end
        2'b10:   begin eo = g_fall & s;   ee = g_fall; end
        2'b01:   begin eo = s | ~g_rise;  ee = 1;      end
        default: begin eo = 0;            ee = 0;      end
      endcase
      tag = {reason(i), gate ? ((mode_of(i) == 2'b01) ? " R7" : " R5") : " R8"};
      if (gate != want_run(i)) tag = {tag, " R4"};
      check(clk_out[i] === eo, {tag, " out"}, clk_out[i], eo);
      check(clk_oe[i] === ee, {tag, " oe"}, clk_oe[i], ee);
    endtask

    always @(posedge src[i]) if (rst_n === 1'b1) begin #1; compare_now(); end
    always @(negedge src[i]) if (rst_n === 1'b1) begin #1; compare_now(); end

    // pulse widths: high pulses in low/hi-z modes, low pulses in held-high mode
    always @(clk_out[i]) begin
      if (rst_n !== 1'b1 || mode_of(i) == 2'b11) begin
        t_valid = 0;
      end else if ((mode_of(i) == 2'b01) ? (clk_out[i] === 1'b0) : (clk_out[i] === 1'b1)) begin
        t_edge = $realtime;
        t_valid = 1;
      end else if (t_valid) begin
        real w;
        w = $realtime - t_edge;
        // R5 R6 full high phase; R7 full low phase
        check(w > half - 0.01 && w < half + 0.01,
              (mode_of(i) == 2'b01) ? "R7 pulse width" : "R5 R6 pulse width",
              int'(w * 10), int'(half * 10));
        t_valid = 0;
      end
    end
  end

  initial begin
    rst_n    = 1'b0;
    pwr_dn   = 1'b0;
    oe_n     = 3'b111;
    // modes: 0 low,1 high,2 hiz,3 unused,4 low,5 high,6 hiz,7 low
    idle_cfg = {2'b00, 2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00};
    link_map = '0;
    link_map[0*N_OUT+0] = 1; link_map[0*N_OUT+1] = 1; link_map[1*N_OUT+1] = 1;
    link_map[1*N_OUT+2] = 1; link_map[2*N_OUT+3] = 1; link_map[0*N_OUT+4] = 1;
    link_map[2*N_OUT+4] = 1; link_map[2*N_OUT+5] = 1; link_map[1*N_OUT+6] = 1;
    link_map[2*N_OUT+6] = 1;
    #0.3;
    #20;
    // R11: idle states while reset is held
    for (int i = 0; i < N_OUT; i++) begin
      bit eo, ee;
      case (mode_of(i))
        2'b00:   begin eo = 0; ee = 1; end
        2'b01:   begin eo = 1; ee = 1; end
        default: begin eo = 0; ee = 0; end
      endcase
      check(clk_out[i] === eo, "R11 reset out", clk_out[i], eo);
      check(clk_oe[i] === ee, "R11 reset oe", clk_oe[i], ee);
    end
    rst_n = 1'b1;
    #200; oe_n = 3'b000;
    #300; oe_n = 3'b010;
    #300; oe_n = 3'b101;
    #300; pwr_dn = 1'b1;
    #300; pwr_dn = 1'b0;
    #300;
    for (int n = 0; n < 400; n++) begin
      oe_n = N_EN'($urandom);
      if ($urandom % 16 == 0) pwr_dn = ~pwr_dn;
      if (n == 200) begin
        link_map = (N_EN*N_OUT)'($urandom);
        for (int j = 0; j < N_EN; j++) link_map[j*N_OUT+7] = 0;
      end
      #(1 + $urandom % 60);
    end
    pwr_dn = 1'b0;
    #300;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule